// File: doc/BRIEF.md
# Programmable SPI Master Controller

This block is a memory-mapped SPI master. Software programs a bit-rate divisor, a 16-bit frame command and a control byte, then writes a word to the data register. Each write moves one frame onto the serial bus. While the frame shifts, the selected active-low chip select is held low. The serial clock runs at the peripheral clock divided by 2×(divisor+1). The frame command sets the frame length, the bit order, the clock polarity and phase, which chip select is used, and whether that chip select stays low once the frame ends.

Received bits are collected into a right-justified receive word. Software reads it back through the same data register. To receive, software writes a dummy word, which produces the clocks for one frame. In transmit-only mode, frames are shifted out and nothing is captured. A transmit-empty flag and a receive-full flag each drive an interrupt request through their own enable. An overrun flag records a frame that was lost because the previous word had not yet been read.

Top module: `spi_master_ctl`

## Requirements
- R1: Every serial-clock half period, including the first one after the chip select falls, lasts exactly (rate+1) peripheral clock cycles. The rate register is at offset 3 and holds 0 to 255.
- R2: Command bits 11:8 set the frame length. Codes 7 to 15 give code+1 bits, code 0 gives 20 bits, code 1 gives 24 bits and code 2 gives 32 bits. Codes 3 to 6 fall back to 8 bits. A frame of N bits produces exactly 2N serial-clock edges.
- R3: Command bit 1 sets the serial-clock idle level. With command bit 0 clear, each bit is sampled on the leading edge and changed on the trailing edge. With bit 0 set, each bit is changed on the leading edge and sampled on the trailing edge. The serial clock is back at its idle level when the frame ends.
- R4: With command bit 12 clear, the frame starts with bit N-1 of the data word. With bit 12 set, it starts with bit 0.
- R5: Command bits 5:4 pick the chip select. Value 0 drives cs_n[0], value 1 drives cs_n[1], and values 2 and 3 drive neither. The chosen chip select is low for the whole frame. It returns high at the end of the frame unless command bit 7 (keep) is set.
- R6: No frame starts unless control bit 6 (enable) and control bit 3 (master) are both set. Clearing enable raises every chip select and abandons any frame in progress.
- R7: Status bit 5 (transmit empty) is 1 after reset. A data write clears it. It is set again when the word moves into the shift engine.
- R8: When a frame completes, the received bits are placed right-justified in the data register with the upper bits zero, and status bit 7 (receive full) is set. A data read returns that word and clears status bit 7.
- R9: Suppose a frame completes while status bit 7 is set and no data read is sampled in that same cycle. Then status bit 0 (overrun) is set and the new word is discarded. If a data read is sampled in the completion cycle, the new word is stored and no overrun occurs. Writing 0 to status bit 0 clears it; writing 1 leaves it unchanged.
- R10: With control bit 1 (transmit only) set, completed frames leave the receive word and status bit 7 untouched.
- R11: irq_tx equals status bit 5 AND control bit 5. irq_rx equals status bit 7 AND control bit 7.
- R12: Register offsets are 0 control, 1 status, 2 data, 3 rate and 4 command. Read data appears on bus_rdata in the cycle after bus_rd is sampled, zero-extended to 32 bits.
- R13: After reset, control, rate and command are zero, status reads 0x20, both chip selects are high and the serial clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 2 | Active-low chip selects |
| irq_tx | output | 1 | Transmit-empty interrupt request |
| irq_rx | output | 1 | Receive-full interrupt request |

## Verification
A software read of the data register and the completion of the next frame can land in the same cycle. In that case the read must count as having drained the receive word, so the new word is stored and no overrun is raised. To provoke this, the bench first leaves one word unread. It then starts a second frame and sweeps the read strobe across the cycles around the completion cycle it predicts arithmetically from the rate and the frame length. At each offset the bench judges the outcome by comparing the status flags and the word later read back with what the timing of the read relative to completion should produce.

// File: rtl/spim_pkg.sv
package spim_pkg;

  localparam logic [2:0] OFS_CTRL = 3'd0;
  localparam logic [2:0] OFS_STAT = 3'd1;
  localparam logic [2:0] OFS_DATA = 3'd2;
  localparam logic [2:0] OFS_RATE = 3'd3;
  localparam logic [2:0] OFS_CMD  = 3'd4;

  localparam int CTL_RXIE = 7;
  localparam int CTL_EN   = 6;
  localparam int CTL_TXIE = 5;
  localparam int CTL_MST  = 3;
  localparam int CTL_TXO  = 1;

  localparam int CMD_LSBF = 12;
  localparam int CMD_KEEP = 7;
  localparam int CMD_CPOL = 1;
  localparam int CMD_CPHA = 0;

  typedef struct packed {
    logic       cpol;
    logic       cpha;
    logic       lsbf;
    logic       keep;
    logic [1:0] sel;
    logic [5:0] len;
  } frame_cfg_t;

  function automatic logic [5:0] frame_bits(input logic [3:0] code);
    logic [5:0] n;
    if (code >= 4'd7)       n = {2'b00, code} + 6'd1;
    else if (code == 4'd0)  n = 6'd20;
    else if (code == 4'd1)  n = 6'd24;
    else if (code == 4'd2)  n = 6'd32;
    else                    n = 6'd8;
    return n;
  endfunction

  function automatic frame_cfg_t decode_cmd(input logic [15:0] cmd);
    frame_cfg_t c;
    c.cpol = cmd[CMD_CPOL];
    c.cpha = cmd[CMD_CPHA];
    c.lsbf = cmd[CMD_LSBF];
    c.keep = cmd[CMD_KEEP];
    c.sel  = cmd[5:4];
    c.len  = frame_bits(cmd[11:8]);
    return c;
  endfunction

endpackage

// File: rtl/spim_rate_gen.sv
module spim_rate_gen #(
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);

  logic [RATE_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run)       cnt_q <= '0;
    else if (cnt_q == rate) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick = run && (cnt_q == rate);

  assert_tick_gap_R1: assert property (@(posedge clk) disable iff (rst)
    (run && tick && rate != '0) |=> (!tick || rate == '0));

endmodule

// File: rtl/spim_shift_engine.sv
module spim_shift_engine
  import spim_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int CS_COUNT = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                abort,
  input  frame_cfg_t          cfg,
  input  logic                idle_cpol,
  input  logic [DATA_W-1:0]   tx_word,
  input  logic                tick,
  input  logic                miso,
  output logic                busy,
  output logic                done,
  output logic [DATA_W-1:0]   rx_word,
  output logic                sclk,
  output logic                mosi,
  output logic [CS_COUNT-1:0] cs_n
);

  localparam int IDX_W  = $clog2(DATA_W);
  localparam int LEN_W  = IDX_W + 1;
  localparam int EDGE_W = LEN_W + 1;

  frame_cfg_t          cfg_q;
  logic [DATA_W-1:0]   tx_q, rx_q;
  logic [EDGE_W-1:0]   edge_q;
  logic [LEN_W-1:0]    bidx_q;
  logic                busy_q, done_q, sclk_q, mosi_q, cs_act_q;
  logic [1:0]          sel_q;
  logic                leading, last_edge, sample_now;
  logic [LEN_W-1:0]    first_pos;

  function automatic logic [IDX_W-1:0] seq_pos(input logic [LEN_W-1:0] k);
    logic [LEN_W-1:0] t;
    t = cfg_q.lsbf ? k : (LEN_W'(cfg_q.len) - LEN_W'(1) - k);
    return t[IDX_W-1:0];
  endfunction

  assign leading    = ~edge_q[0];
  assign last_edge  = (edge_q == (EDGE_W'({cfg_q.len, 1'b0}) - EDGE_W'(1)));
  assign sample_now = leading ^ cfg_q.cpha;
  assign first_pos  = LEN_W'(cfg.len) - LEN_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
      edge_q   <= '0;
      bidx_q   <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      sclk_q   <= 1'b0;
      mosi_q   <= 1'b0;
      cs_act_q <= 1'b0;
      sel_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (abort) begin
        busy_q   <= 1'b0;
        cs_act_q <= 1'b0;
        sclk_q   <= idle_cpol;
      end else if (!busy_q) begin
        sclk_q <= idle_cpol;
        if (start) begin
          busy_q   <= 1'b1;
          cfg_q    <= cfg;
          tx_q     <= tx_word;
          rx_q     <= '0;
          edge_q   <= '0;
          bidx_q   <= '0;
          cs_act_q <= 1'b1;
          sel_q    <= cfg.sel;
          sclk_q   <= cfg.cpol;
          mosi_q   <= cfg.lsbf ? tx_word[0] : tx_word[first_pos[IDX_W-1:0]];
        end
      end else if (tick) begin
        sclk_q <= ~sclk_q;
        edge_q <= edge_q + 1'b1;
        if (sample_now) rx_q[seq_pos(bidx_q)] <= miso;
        if (cfg_q.cpha) begin
          if (leading) mosi_q <= tx_q[seq_pos(bidx_q)];
          else         bidx_q <= bidx_q + 1'b1;
        end else if (!leading) begin
          bidx_q <= bidx_q + 1'b1;
          if (!last_edge) mosi_q <= tx_q[seq_pos(bidx_q + 1'b1)];
        end
        if (last_edge) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          if (!cfg_q.keep) cs_act_q <= 1'b0;
        end
      end
    end
  end

  for (genvar i = 0; i < CS_COUNT; i++) begin : g_cs
    assign cs_n[i] = ~(cs_act_q && (sel_q == 2'(i)));
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign rx_word = rx_q;
  assign sclk    = sclk_q;
  assign mosi    = mosi_q;

  assert_idle_level_at_end_R3: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (sclk_q == cfg_q.cpol));

  assert_cs_held_in_frame_R5: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> cs_act_q);

endmodule

// File: rtl/spi_master_ctl.sv
module spi_master_ctl
  import spim_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int RATE_W   = 8,
  parameter int CS_COUNT = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [2:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic                sclk,
  output logic                mosi,
  input  logic                miso,
  output logic [CS_COUNT-1:0] cs_n,
  output logic                irq_tx,
  output logic                irq_rx
);

  localparam int PAD_W = 32 - DATA_W;

  logic [7:0]        ctrl_q;
  logic [RATE_W-1:0] rate_q;
  logic [15:0]       cmd_q;
  logic [DATA_W-1:0] txbuf_q, rxbuf_q;
  logic              txe_q, rxf_q, ovr_q;
  logic [31:0]       rdata_q;

  logic wr_ctrl, wr_stat, wr_data, wr_rate, wr_cmd, rd_data;
  logic start, busy, frame_done, tick, rx_take;
  logic [DATA_W-1:0] rx_word;
  logic [7:0] stat_byte;

  assign wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
  assign wr_stat = bus_wr && (bus_addr == OFS_STAT);
  assign wr_data = bus_wr && (bus_addr == OFS_DATA);
  assign wr_rate = bus_wr && (bus_addr == OFS_RATE);
  assign wr_cmd  = bus_wr && (bus_addr == OFS_CMD);
  assign rd_data = bus_rd && (bus_addr == OFS_DATA);

  assign start   = ctrl_q[CTL_EN] && ctrl_q[CTL_MST] && !txe_q && !busy;
  assign rx_take = frame_done && !ctrl_q[CTL_TXO];
  assign stat_byte = {rxf_q, 1'b0, txe_q, 4'b0000, ovr_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      rate_q <= '0;
      cmd_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata[7:0];
      if (wr_rate) rate_q <= bus_wdata[RATE_W-1:0];
      if (wr_cmd)  cmd_q  <= bus_wdata[15:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txbuf_q <= '0;
      txe_q   <= 1'b1;
    end else if (wr_data) begin
      txbuf_q <= bus_wdata[DATA_W-1:0];
      txe_q   <= 1'b0;
    end else if (start) begin
      txe_q   <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rxbuf_q <= '0;
      rxf_q   <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (rx_take) begin
        if (rxf_q && !rd_data) begin
          ovr_q <= 1'b1;
        end else begin
          rxbuf_q <= rx_word;
          rxf_q   <= 1'b1;
        end
      end else if (rd_data) begin
        rxf_q <= 1'b0;
      end
      if (wr_stat && !bus_wdata[0] && !(rx_take && rxf_q && !rd_data))
        ovr_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        OFS_CTRL: rdata_q <= {24'd0, ctrl_q};
        OFS_STAT: rdata_q <= {24'd0, stat_byte};
        OFS_DATA: rdata_q <= {{PAD_W{1'b0}}, rxbuf_q};
        OFS_RATE: rdata_q <= {{(32-RATE_W){1'b0}}, rate_q};
        OFS_CMD:  rdata_q <= {16'd0, cmd_q};
        default:  rdata_q <= '0;
      endcase
    end
  end

  spim_rate_gen #(.RATE_W(RATE_W)) u_rate (
    .clk  (clk),
    .rst  (rst),
    .run  (busy),
    .rate (rate_q),
    .tick (tick)
  );

  spim_shift_engine #(.DATA_W(DATA_W), .CS_COUNT(CS_COUNT)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .abort     (!ctrl_q[CTL_EN]),
    .cfg       (decode_cmd(cmd_q)),
    .idle_cpol (cmd_q[CMD_CPOL]),
    .tx_word   (txbuf_q),
    .tick      (tick),
    .miso      (miso),
    .busy      (busy),
    .done      (frame_done),
    .rx_word   (rx_word),
    .sclk      (sclk),
    .mosi      (mosi),
    .cs_n      (cs_n)
  );

  assign bus_rdata = rdata_q;
  assign irq_tx    = txe_q && ctrl_q[CTL_TXIE];
  assign irq_rx    = rxf_q && ctrl_q[CTL_RXIE];

  assert_cs_release_on_disable_R6: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[CTL_EN] |=> (&cs_n));

  assert_write_clears_empty_R7: assert property (@(posedge clk) disable iff (rst)
    wr_data |=> !txe_q);

  assert_lost_frame_flags_R9: assert property (@(posedge clk) disable iff (rst)
    (frame_done && rxf_q && !rd_data && !ctrl_q[CTL_TXO]) |=> ovr_q);

  assert_txonly_no_capture_R10: assert property (@(posedge clk) disable iff (rst)
    (frame_done && ctrl_q[CTL_TXO] && !rxf_q && !rd_data) |=> !rxf_q);

endmodule

// File: tb/sim_spi_master_ctl.sv
module sim_spi_master_ctl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sclk, mosi, miso, irq_tx, irq_rx;
  logic [1:0]  cs_n;

  assign miso = mosi;
  always #5 clk = ~clk;

  spi_master_ctl u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n),
    .irq_tx(irq_tx), .irq_rx(irq_rx)
  );

  int nchk = 0, nfail = 0;
  bit finished = 0;

  logic mon_cpol = 0, mon_cpha = 0;
  int   mon_rate = 0;
  int   tog_n = 0, cap_n = 0, per_err = 0, cyc = 0;
  logic cap [64];
  logic prev_sclk = 0;
  logic prev_cs0 = 1;

  always @(negedge clk) begin
    if (prev_cs0 && !cs_n[0]) cyc = 0;
    else begin
      cyc++;
      if (sclk !== prev_sclk) begin
        if (cyc != mon_rate + 1) per_err++;
        cyc = 0;
        tog_n++;
        if ((sclk != mon_cpol) ^ mon_cpha) begin
          if (cap_n < 64) cap[cap_n] = mosi;
          cap_n++;
        end
      end
    end
    prev_sclk = sclk;
    prev_cs0  = cs_n[0];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  function automatic int flen(input int code);
    if (code >= 7) return code + 1;
    if (code == 0) return 20;
    if (code == 1) return 24;
    if (code == 2) return 32;
    return 8;
  endfunction

  function automatic logic [31:0] lmask(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 1);
  endfunction

  task automatic arm(input logic [15:0] cmd, input int rate);
    mon_cpol = cmd[1]; mon_cpha = cmd[0]; mon_rate = rate;
    tog_n = 0; cap_n = 0; per_err = 0;
  endtask

  task automatic wait_frame(input int len, input int rate);
    repeat (2 * len * (rate + 1) + 4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv, d, a, b;
    logic [15:0] cmd;
    int len, mism, tsnap;
    int codes [7] = '{7, 10, 15, 0, 1, 2, 4};

    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R13 reset state
    chk("R13 cs_n", {30'd0, cs_n}, 32'd3);
    chk("R13 sclk", {31'd0, sclk}, 32'd0);
    rd(3'd1, rv); chk("R13/R7 status", rv, 32'h20);
    rd(3'd4, rv); chk("R13 cmd", rv, 32'h0);
    chk("R11 irq idle", {30'd0, irq_tx, irq_rx}, 32'd0);

    // R12 register map
    wr(3'd3, 32'hFF5A); rd(3'd3, rv); chk("R12 rate", rv, 32'h5A);
    wr(3'd4, 32'h1234); rd(3'd4, rv); chk("R12 cmd", rv, 32'h1234);
    wr(3'd0, 32'h108); rd(3'd0, rv); chk("R12 ctrl", rv, 32'h08);

    // R1 R2 R3 R4 R8 sweep
    for (int m = 0; m < 4; m++)
      for (int lb = 0; lb < 2; lb++)
        for (int ci = 0; ci < 7; ci++)
          for (int rt = 0; rt < 4; rt += 3) begin
            len = flen(codes[ci]);
            cmd = 16'(lb << 12) | 16'(codes[ci] << 8) | 16'(m);
            d = (32'h9E37_79B9 * 32'(m * 97 + lb * 31 + ci * 7 + rt + 1)) ^ 32'h5A3C_0F69;
            wr(3'd3, 32'(rt)); wr(3'd4, {16'd0, cmd}); wr(3'd0, 32'h48);
            arm(cmd, rt);
            wr(3'd2, d);
            wait_frame(len, rt);
            chk("R2 edge count", 32'(tog_n), 32'(2 * len));
            chk("R1 half period errors", 32'(per_err), 32'd0);
            mism = 0;
            for (int k = 0; k < len; k++)
              if (cap[k] !== (lb ? d[k] : d[len - 1 - k])) mism++;
            if (lb) chk("R4 lsb-first order", 32'(mism), 32'd0);
            else    chk("R3 msb-first sampled bits", 32'(mism), 32'd0);
            chk("R3 sclk idle after", {31'd0, sclk}, {31'd0, cmd[1]});
            chk("R5 cs released", {30'd0, cs_n}, 32'd3);
            rd(3'd1, rv); chk("R8 status full", rv, 32'hA0);
            rd(3'd2, rv); chk("R8 rx word", rv, d & lmask(len));
            rd(3'd1, rv); chk("R8 read clears", rv, 32'h20);
          end

    // R5 chip select choice and keep
    wr(3'd3, 32'd1); wr(3'd4, 32'h0710); arm(16'h0710, 1);
    wr(3'd2, 32'hC3);
    repeat (5) @(negedge clk);
    chk("R5 sel1 active", {30'd0, cs_n}, 32'd1);
    wait_frame(8, 1); rd(3'd2, rv);
    wr(3'd4, 32'h0720); wr(3'd2, 32'h3C);
    repeat (5) @(negedge clk);
    chk("R5 sel2 none", {30'd0, cs_n}, 32'd3);
    wait_frame(8, 1); rd(3'd2, rv);
    chk("R5 sel2 frame ran", rv, 32'h3C);
    wr(3'd4, 32'h0780); arm(16'h0780, 1);
    wr(3'd2, 32'h81);
    wait_frame(8, 1);
    chk("R5 keep holds cs", {30'd0, cs_n}, 32'd2);
    wr(3'd0, 32'h08);
    @(negedge clk);
    chk("R6 disable releases cs", {30'd0, cs_n}, 32'd3);
    rd(3'd2, rv);

    // R6 master bit required
    wr(3'd4, 32'h0700); wr(3'd0, 32'h40); arm(16'h0700, 1);
    wr(3'd2, 32'h5E);
    repeat (40) @(negedge clk);
    chk("R6 no frame without master", 32'(tog_n), 32'd0);
    rd(3'd1, rv); chk("R7 pending word keeps empty low", rv, 32'h00);
    wr(3'd0, 32'h48);
    wait_frame(8, 1);
    rd(3'd1, rv); chk("R6 frame after master", rv, 32'hA0);
    rd(3'd2, rv); chk("R8 late frame word", rv, 32'h5E);

    // R6 abort mid frame
    wr(3'd3, 32'd3); wr(3'd4, 32'h0F02); arm(16'h0F02, 3);
    wr(3'd2, 32'hBEEF);
    repeat (20) @(negedge clk);
    wr(3'd0, 32'h08);
    repeat (2) @(negedge clk);
    chk("R6 abort cs", {30'd0, cs_n}, 32'd3);
    chk("R6 abort sclk idle", {31'd0, sclk}, 32'd1);
    tsnap = tog_n;
    repeat (50) @(negedge clk);
    chk("R6 abort stops clock", 32'(tog_n), 32'(tsnap));
    rd(3'd1, rv); chk("R6 abort no rx", rv, 32'h20);

    // R7 write while busy, R9 overrun and clear
    wr(3'd3, 32'd0); wr(3'd4, 32'h0700); wr(3'd0, 32'h48); arm(16'h0700, 0);
    wr(3'd2, 32'h11);
    repeat (3) @(negedge clk);
    wr(3'd2, 32'h22);
    rd(3'd1, rv); chk("R7 empty low while busy", rv, 32'h00);
    wait_frame(16, 0);
    rd(3'd1, rv); chk("R9 overrun set", rv, 32'hA1);
    wr(3'd1, 32'h01); rd(3'd1, rv); chk("R9 write 1 keeps", rv, 32'hA1);
    wr(3'd1, 32'h00); rd(3'd1, rv); chk("R9 write 0 clears", rv, 32'hA0);
    rd(3'd2, rv); chk("R9 first word kept", rv, 32'h11);

    // R10 transmit only
    wr(3'd0, 32'h4A); arm(16'h0700, 0);
    wr(3'd2, 32'h77);
    wait_frame(8, 0);
    chk("R10 frame shifted", 32'(tog_n), 32'd16);
    rd(3'd1, rv); chk("R10 no capture flag", rv, 32'h20);
    rd(3'd2, rv); chk("R10 rx word untouched", rv, 32'h11);

    // R11 interrupts
    wr(3'd0, 32'hE8);
    @(negedge clk);
    chk("R11 tx irq", {30'd0, irq_tx, irq_rx}, 32'd2);
    wr(3'd2, 32'h99);
    wait_frame(8, 0);
    chk("R11 rx irq", {30'd0, irq_tx, irq_rx}, 32'd3);
    rd(3'd2, rv);
    @(negedge clk);
    chk("R11 rx irq drops", {30'd0, irq_tx, irq_rx}, 32'd2);
    wr(3'd0, 32'h48);
    @(negedge clk);
    chk("R11 masked", {30'd0, irq_tx, irq_rx}, 32'd0);

    // R9 read versus completion sweep: rate 0, 8 bits, completion at write edge + 18
    for (int dd = 15; dd <= 21; dd++) begin
      a = 32'(8'hA0 + dd); b = 32'(8'h50 + dd);
      wr(3'd2, a);
      wait_frame(8, 0);
      wr(3'd2, b);
      repeat (dd - 1) @(negedge clk);
      bus_rd = 1; bus_addr = 3'd2;
      @(negedge clk);
      bus_rd = 0;
      chk("R9 coincident read returns old", bus_rdata, a);
      wait_frame(8, 0);
      rd(3'd1, rv);
      if (dd <= 18) begin
        chk("R9 read in time no overrun", rv, 32'hA0);
        rd(3'd2, rv); chk("R9 new word stored", rv, b);
      end else begin
        chk("R9 late read overrun", rv, 32'h21);
        rd(3'd2, rv); chk("R9 new word dropped", rv, a);
        wr(3'd1, 32'h0);
      end
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule